// File: doc/BRIEF.md
# Call Frame Pointer Controller

This block keeps the three frame pointers of a hardware function-call unit: the open frame (where the arguments for the next call are built), the active frame (the running function) and the return frame (where results go back to the caller). It also holds the return-PC and return-destination of the innermost call. It drives an external frame-header RAM with one word per frame. Each word holds a saved open pointer, a saved active pointer, a return-PC and a return-destination. An external free-frame allocator hands out frame numbers and takes them back.

Each call operation is accepted when `ready` is high and takes two clock cycles. In the decode cycle the operation code is applied and the header address for the next cycle is latched. In the read/write cycle the header RAM is read or written at that registered address. At the end of every operation the header address is left pointing at the active frame. A following return or tail operation can therefore read the active header during its own decode cycle, and two returns can run back to back.

When an instruction is accepted, shadow copies of the three pointers are taken. The trap input rolls the pointers back to those copies in one clock. While the trap input is high, no header write, allocation or release takes place.

Top module: `frame_ptr_ctl`

## Requirements
- R1: After reset, the open, active and return pointers, return-PC and return-destination are all zero. `ready` is 1, and `alloc_req`, `free_req`, `hdr_we_link` and `hdr_we_ret` are 0.
- R2: Open (code 1) raises `alloc_req` in the decode cycle and takes `alloc_frame` as the new open pointer. In the second cycle it writes the previous open and active pointers into the link fields of the new frame's header. The return fields are left unwritten and the active pointer is unchanged.
- R3: Call (code 2) writes `pc_next` and `ret_dst_in` into the return fields of the open frame's header. The active pointer then equals the open pointer, and `ret_pc`/`ret_dst` show the values just written.
- R4: Open-call (code 3) allocates a frame and writes all four header fields: the previous open, the previous active, `pc_next` and `ret_dst_in`. Both the open and the active pointer then name the new frame.
- R5: Tail-open (code 4) allocates a frame, copies the whole header of the active frame into it, and makes it the open frame.
- R6: Tail-call (code 5) releases the return frame during decode (`free_req`=1, `free_frame`=old return pointer). The return pointer becomes the old active pointer and the active pointer becomes the open pointer. `ret_pc`/`ret_dst` are then loaded from the open frame's header.
- R7: Return (code 6) releases the return frame and sets the return pointer to the old active pointer. It restores the open and active pointers from the link fields of the active header. It then loads `ret_pc`/`ret_dst` from the header of the new active frame, so that a second return may follow at once.
- R8: Cancel-open (code 7) releases the open frame (`free_frame`=open pointer) and restores the open and active pointers from the link fields of the open frame's header.
- R9: No-op (code 0) leaves all pointers unchanged and loads `ret_pc`/`ret_dst` from the active frame's header.
- R10: While `trap_in` is 1, `ready`, `alloc_req`, `free_req` and both header write strobes are 0. After that clock, the three pointers equal their values at the start of the last accepted instruction.
- R11: Header write strobes are raised only in the second cycle of an operation, and `hdr_addr` changes only on a clock edge. The header word is packed as {open[FW], active[FW], return-PC[PCW], return-dest[DW]}, most significant field first.
- R12: `op_go` is ignored while `ready` is 0: no allocation, release or pointer change results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_go | input | 1 | Start an operation (taken when ready) |
| op_code | input | 3 | Operation code |
| pc_next | input | PCW | Address of the instruction after the call |
| ret_dst_in | input | DW | Return destination from the instruction |
| trap_in | input | 1 | Trap-entry rollback request |
| ready | output | 1 | Block can accept an operation this cycle |
| alloc_req | output | 1 | Consume `alloc_frame` from the allocator |
| alloc_frame | input | FW | Next free frame offered by the allocator |
| free_req | output | 1 | Release `free_frame` to the allocator |
| free_frame | output | FW | Frame being released |
| hdr_addr | output | FW | Registered header RAM address |
| hdr_rdata | input | HW | Header word at `hdr_addr` |
| hdr_wdata | output | HW | Header word to write |
| hdr_we_link | output | 1 | Write the open/active link fields |
| hdr_we_ret | output | 1 | Write the return-PC/destination fields |
| o_ptr | output | FW | Open frame pointer |
| a_ptr | output | FW | Active frame pointer |
| r_ptr | output | FW | Return frame pointer |
| ret_pc | output | PCW | Held return-PC |
| ret_dst | output | DW | Held return destination |

## Verification
A trap rollback and a header write can coincide in the second cycle of an open, since the write strobe and the trap both act in that cycle. The bench provokes this by starting an open and raising `trap_in` one cycle later. It then requires the write strobe to stay low in that cycle, the new frame's header in the bench RAM to keep its old contents, and all three pointers to come back to their values from before the open. A second overlap, an operation request arriving while the block is busy, is judged by holding `op_go` high through a no-op's second cycle and checking that no allocation occurs and no pointer moves.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_OPEN   = 3'd1,
    OP_CALL   = 3'd2,
    OP_OCALL  = 3'd3,
    OP_TOPEN  = 3'd4,
    OP_TCALL  = 3'd5,
    OP_RET    = 3'd6,
    OP_CANCEL = 3'd7
  } op_e;
endpackage

// File: rtl/fcp_phase.sv
// Two-phase operation sequencer: decode cycle, then header access cycle.
module fcp_phase
  import fcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_go,
  input  logic [2:0] op_code,
  input  logic       trap_in,
  output logic       ready,
  output logic       accept,
  output logic       ph_acc,
  output op_e        op_q
);
  logic ph_n;
  op_e  op_n;

  assign ready  = !ph_acc && !trap_in;
  assign accept = ready && op_go;

  always_comb begin
    ph_n = ph_acc;
    op_n = op_q;
    if (trap_in) begin
      ph_n = 1'b0;
    end else if (accept) begin
      ph_n = 1'b1;
      op_n = op_e'(op_code);
    end else if (ph_acc) begin
      ph_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_acc <= 1'b0;
      op_q   <= OP_NOP;
    end else begin
      ph_acc <= ph_n;
      if (accept) op_q <= op_n;
    end
  end
endmodule

// File: rtl/fcp_shadow.sv
// Shadow copies of the frame pointers, taken at instruction start.
module fcp_shadow #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [FW-1:0] o_in,
  input  logic [FW-1:0] a_in,
  input  logic [FW-1:0] r_in,
  output logic [FW-1:0] sh_o,
  output logic [FW-1:0] sh_a,
  output logic [FW-1:0] sh_r
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_o <= '0;
      sh_a <= '0;
      sh_r <= '0;
    end else if (capture) begin
      sh_o <= o_in;
      sh_a <= a_in;
      sh_r <= r_in;
    end
  end
endmodule

// File: rtl/frame_ptr_ctl.sv
module frame_ptr_ctl
  import fcp_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int PCW    = 16,
  parameter int DW     = 6,
  localparam int FW    = $clog2(FRAMES),
  localparam int HW    = 2 * FW + PCW + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_go,
  input  logic [2:0]     op_code,
  input  logic [PCW-1:0] pc_next,
  input  logic [DW-1:0]  ret_dst_in,
  input  logic           trap_in,
  output logic           ready,
  output logic           alloc_req,
  input  logic [FW-1:0]  alloc_frame,
  output logic           free_req,
  output logic [FW-1:0]  free_frame,
  output logic [FW-1:0]  hdr_addr,
  input  logic [HW-1:0]  hdr_rdata,
  output logic [HW-1:0]  hdr_wdata,
  output logic           hdr_we_link,
  output logic           hdr_we_ret,
  output logic [FW-1:0]  o_ptr,
  output logic [FW-1:0]  a_ptr,
  output logic [FW-1:0]  r_ptr,
  output logic [PCW-1:0] ret_pc,
  output logic [DW-1:0]  ret_dst
);
  logic          accept, ph_acc;
  op_e           op_q;
  logic [FW-1:0] sh_o, sh_a, sh_r;

  logic [FW-1:0]  o_q, a_q, r_q, to_q, ta_q, haddr_q;
  logic [FW-1:0]  o_n, a_n, r_n, to_n, ta_n, haddr_n;
  logic [PCW-1:0] rpc_q, rpc_n;
  logic [DW-1:0]  rdst_q, rdst_n;

  // Header word fields
  logic [FW-1:0]  h_o, h_a;
  logic [PCW-1:0] h_pc;
  logic [DW-1:0]  h_dst;
  assign h_o   = hdr_rdata[HW-1 -: FW];
  assign h_a   = hdr_rdata[HW-FW-1 -: FW];
  assign h_pc  = hdr_rdata[DW+PCW-1 -: PCW];
  assign h_dst = hdr_rdata[DW-1:0];

  fcp_phase u_phase (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .trap_in(trap_in), .ready(ready), .accept(accept),
    .ph_acc(ph_acc), .op_q(op_q)
  );

  fcp_shadow #(.FW(FW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .capture(accept),
    .o_in(o_q), .a_in(a_q), .r_in(r_q),
    .sh_o(sh_o), .sh_a(sh_a), .sh_r(sh_r)
  );

  always_comb begin
    o_n = o_q;  a_n = a_q;  r_n = r_q;
    to_n = to_q;  ta_n = ta_q;  haddr_n = haddr_q;
    rpc_n = rpc_q;  rdst_n = rdst_q;
    alloc_req   = 1'b0;
    free_req    = 1'b0;
    free_frame  = r_q;
    hdr_we_link = 1'b0;
    hdr_we_ret  = 1'b0;
    if (trap_in) begin
      o_n = sh_o;  a_n = sh_a;  r_n = sh_r;  haddr_n = sh_a;
    end else if (accept) begin
      case (op_e'(op_code))
        OP_NOP: haddr_n = a_q;
        OP_OPEN: begin
          alloc_req = 1'b1;  haddr_n = alloc_frame;
          to_n = o_q;  ta_n = a_q;  o_n = alloc_frame;
        end
        OP_CALL: begin
          haddr_n = o_q;  rpc_n = pc_next;  rdst_n = ret_dst_in;
        end
        OP_OCALL: begin
          alloc_req = 1'b1;  haddr_n = alloc_frame;
          to_n = o_q;  ta_n = a_q;  o_n = alloc_frame;
          rpc_n = pc_next;  rdst_n = ret_dst_in;
        end
        OP_TOPEN: begin
          alloc_req = 1'b1;  haddr_n = alloc_frame;  o_n = alloc_frame;
          to_n = h_o;  ta_n = h_a;  rpc_n = h_pc;  rdst_n = h_dst;
        end
        OP_TCALL: begin
          free_req = 1'b1;  haddr_n = o_q;  r_n = a_q;  a_n = o_q;
        end
        OP_RET: begin
          free_req = 1'b1;  r_n = a_q;
          o_n = h_o;  a_n = h_a;  haddr_n = h_a;
        end
        OP_CANCEL: begin
          free_req = 1'b1;  free_frame = o_q;  haddr_n = o_q;
        end
        default: ;
      endcase
    end else if (ph_acc) begin
      case (op_q)
        OP_NOP, OP_TCALL, OP_RET: begin
          rpc_n = h_pc;  rdst_n = h_dst;
        end
        OP_OPEN:  hdr_we_link = 1'b1;
        OP_CALL: begin
          hdr_we_ret = 1'b1;  a_n = o_q;
        end
        OP_OCALL: begin
          hdr_we_link = 1'b1;  hdr_we_ret = 1'b1;  a_n = o_q;
        end
        OP_TOPEN: begin
          hdr_we_link = 1'b1;  hdr_we_ret = 1'b1;
        end
        OP_CANCEL: begin
          o_n = h_o;  a_n = h_a;
        end
        default: ;
      endcase
      haddr_n = a_n;  // park on the active frame for the next decode
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_q <= '0;  a_q <= '0;  r_q <= '0;
      to_q <= '0;  ta_q <= '0;  haddr_q <= '0;
      rpc_q <= '0;  rdst_q <= '0;
    end else begin
      o_q <= o_n;  a_q <= a_n;  r_q <= r_n;
      to_q <= to_n;  ta_q <= ta_n;  haddr_q <= haddr_n;
      rpc_q <= rpc_n;  rdst_q <= rdst_n;
    end
  end

  assign hdr_addr  = haddr_q;
  assign hdr_wdata = {to_q, ta_q, rpc_q, rdst_q};
  assign o_ptr     = o_q;
  assign a_ptr     = a_q;
  assign r_ptr     = r_q;
  assign ret_pc    = rpc_q;
  assign ret_dst   = rdst_q;
endmodule

// File: rtl/fcp_chk.sv
module fcp_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_go,
  input logic [2:0]    op_code,
  input logic          trap_in,
  input logic          ready,
  input logic          ph_acc,
  input logic          alloc_req,
  input logic          free_req,
  input logic [FW-1:0] free_frame,
  input logic          hdr_we_link,
  input logic          hdr_we_ret,
  input logic [FW-1:0] o_ptr,
  input logic [FW-1:0] a_ptr,
  input logic [FW-1:0] r_ptr,
  input logic [FW-1:0] sh_o,
  input logic [FW-1:0] sh_a,
  input logic [FW-1:0] sh_r
);
  // R10: trap blocks every side effect
  p_trap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |-> (!hdr_we_link && !hdr_we_ret && !alloc_req && !free_req && !ready));

  // R10: one-clock rollback to the shadow copies
  p_trap_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> (o_ptr == $past(sh_o) && a_ptr == $past(sh_a) && r_ptr == $past(sh_r)));

  // R11: header writes only in the access cycle
  p_write_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_we_link || hdr_we_ret) |-> ph_acc);

  // R12: no allocation or release without an accepted request
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req || free_req) |-> (ready && op_go));

  // R7: return releases the current return frame
  p_ret_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_go && op_code == 3'd6) |-> (free_req && free_frame == r_ptr));

  // R3: after an untrapped call the active pointer equals the open pointer
  p_call_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_go && op_code == 3'd2) ##1 !trap_in |=> (a_ptr == o_ptr));
endmodule

bind frame_ptr_ctl fcp_chk #(.FW(FW)) u_fcp_chk (
  .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
  .trap_in(trap_in), .ready(ready), .ph_acc(ph_acc),
  .alloc_req(alloc_req), .free_req(free_req), .free_frame(free_frame),
  .hdr_we_link(hdr_we_link), .hdr_we_ret(hdr_we_ret),
  .o_ptr(o_ptr), .a_ptr(a_ptr), .r_ptr(r_ptr),
  .sh_o(sh_o), .sh_a(sh_a), .sh_r(sh_r)
);

// File: tb/frame_ptr_ctl_bench.sv
`timescale 1ns/1ps
module frame_ptr_ctl_bench;
  localparam int FRAMES = 16, PCW = 16, DW = 6;
  localparam int FW = $clog2(FRAMES);
  localparam int HW = 2 * FW + PCW + DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_go = 1'b0, trap_in = 1'b0;
  logic [2:0] op_code = '0;
  logic [PCW-1:0] pc_next = '0;
  logic [DW-1:0] ret_dst_in = '0;
  logic [FW-1:0] alloc_frame = '0;
  logic ready, alloc_req, free_req, hdr_we_link, hdr_we_ret;
  logic [FW-1:0] free_frame, hdr_addr, o_ptr, a_ptr, r_ptr;
  logic [HW-1:0] hdr_rdata, hdr_wdata;
  logic [PCW-1:0] ret_pc;
  logic [DW-1:0] ret_dst;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Bench model of the external header RAM
  logic [FW-1:0]  m_o [FRAMES];
  logic [FW-1:0]  m_a [FRAMES];
  logic [PCW-1:0] m_pc[FRAMES];
  logic [DW-1:0]  m_dst[FRAMES];
  assign hdr_rdata = {m_o[hdr_addr], m_a[hdr_addr], m_pc[hdr_addr], m_dst[hdr_addr]};
  always @(posedge clk) begin
    if (hdr_we_link) begin
      m_o[hdr_addr] <= hdr_wdata[HW-1 -: FW];
      m_a[hdr_addr] <= hdr_wdata[HW-FW-1 -: FW];
    end
    if (hdr_we_ret) begin
      m_pc[hdr_addr]  <= hdr_wdata[DW+PCW-1 -: PCW];
      m_dst[hdr_addr] <= hdr_wdata[DW-1:0];
    end
  end

  frame_ptr_ctl u_frame_ptr_ctl (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_code(op_code),
    .pc_next(pc_next), .ret_dst_in(ret_dst_in), .trap_in(trap_in),
    .ready(ready), .alloc_req(alloc_req), .alloc_frame(alloc_frame),
    .free_req(free_req), .free_frame(free_frame), .hdr_addr(hdr_addr),
    .hdr_rdata(hdr_rdata), .hdr_wdata(hdr_wdata),
    .hdr_we_link(hdr_we_link), .hdr_we_ret(hdr_we_ret),
    .o_ptr(o_ptr), .a_ptr(a_ptr), .r_ptr(r_ptr),
    .ret_pc(ret_pc), .ret_dst(ret_dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ptrs(input string req, input int o, input int a, input int r);
    chk(req, o_ptr, o);
    chk(req, a_ptr, a);
    chk(req, r_ptr, r);
  endtask

  // Captured strobes of the last operation
  logic d_alloc, d_free, d_we, r_we_link, r_we_ret;
  logic [FW-1:0] d_ff, r_addr;

  task automatic run_op(input int code, input int af, input int pc, input int rd);
    @(negedge clk);
    op_go = 1'b1; op_code = 3'(code); alloc_frame = FW'(af);
    pc_next = PCW'(pc); ret_dst_in = DW'(rd);
    #1;
    d_alloc = alloc_req; d_free = free_req; d_ff = free_frame;
    d_we = hdr_we_link | hdr_we_ret;
    @(negedge clk);
    op_go = 1'b0;
    #1;
    r_we_link = hdr_we_link; r_we_ret = hdr_we_ret; r_addr = hdr_addr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_ptrs("R1", 0, 0, 0);
    chk("R1", ret_pc, 0); chk("R1", ret_dst, 0);
    chk("R1", ready, 1); chk("R1", alloc_req, 0); chk("R1", free_req, 0);
    chk("R1", hdr_we_link | hdr_we_ret, 0);
  endtask

  task automatic t_open_call;  // R4
    run_op(3, 1, 100, 5);
    chk("R4 alloc", d_alloc, 1);
    chk_ptrs("R4", 1, 1, 0);
    chk("R4 hdr", {m_o[1], m_a[1]}, 0);
    chk("R4 pc", m_pc[1], 100); chk("R4 dst", m_dst[1], 5);
    chk("R4 rpc", ret_pc, 100);
  endtask

  task automatic t_open;  // R2, R11
    run_op(1, 2, 0, 0);
    chk("R2 alloc", d_alloc, 1);
    chk("R11 no write in decode", d_we, 0);
    chk("R11 write in access", r_we_link, 1);
    chk("R11 addr", r_addr, 2);
    chk("R2 ret untouched", r_we_ret, 0);
    chk_ptrs("R2", 2, 1, 0);
    chk("R2 link o", m_o[2], 1); chk("R2 link a", m_a[2], 1);
    chk("R2 pc untouched", m_pc[2], 0);
  endtask

  task automatic t_call;  // R3
    run_op(2, 0, 300, 7);
    chk("R3 alloc", d_alloc, 0);
    chk_ptrs("R3", 2, 2, 0);
    chk("R3 pc", m_pc[2], 300); chk("R3 dst", m_dst[2], 7);
    chk("R3 link kept", m_o[2], 1);
    chk("R3 rpc", ret_pc, 300); chk("R3 rdst", ret_dst, 7);
  endtask

  task automatic t_tail_open;  // R5
    run_op(4, 3, 0, 0);
    chk("R5 alloc", d_alloc, 1);
    chk_ptrs("R5", 3, 2, 0);
    chk("R5 o", m_o[3], 1); chk("R5 a", m_a[3], 1);
    chk("R5 pc", m_pc[3], 300); chk("R5 dst", m_dst[3], 7);
  endtask

  task automatic t_cancel;  // R8
    run_op(7, 0, 0, 0);
    chk("R8 free", d_free, 1); chk("R8 frame", d_ff, 3);
    chk_ptrs("R8", 1, 1, 0);
  endtask

  task automatic t_nop_busy;  // R9, R12
    @(negedge clk);
    op_go = 1'b1; op_code = 3'd0;
    @(negedge clk);
    op_code = 3'd1; alloc_frame = 4'd9;  // held request while busy
    #1;
    chk("R12 no alloc while busy", alloc_req, 0);
    chk("R12 not ready", ready, 0);
    @(negedge clk);
    op_go = 1'b0;
    chk_ptrs("R9", 1, 1, 0);
    chk("R9 rpc", ret_pc, 100); chk("R9 rdst", ret_dst, 5);
    @(negedge clk);
    chk("R12 open ignored", o_ptr, 1);
  endtask

  task automatic t_tail_call;  // R6
    run_op(1, 4, 0, 0);
    chk_ptrs("R2 second open", 4, 1, 0);
    m_pc[4] = 16'd450; m_dst[4] = 6'd11;
    run_op(5, 0, 0, 0);
    chk("R6 free", d_free, 1); chk("R6 frame", d_ff, 0);
    chk_ptrs("R6", 4, 4, 1);
    chk("R6 rpc", ret_pc, 450); chk("R6 rdst", ret_dst, 11);
  endtask

  task automatic t_trap;  // R10
    @(negedge clk);
    op_go = 1'b1; op_code = 3'd1; alloc_frame = 4'd5;
    @(negedge clk);
    op_go = 1'b0; trap_in = 1'b1;
    #1;
    chk("R10 write blocked", hdr_we_link | hdr_we_ret, 0);
    chk("R10 ready low", ready, 0);
    chk("R10 no alloc", alloc_req, 0);
    @(negedge clk);
    trap_in = 1'b0;
    #1;
    chk_ptrs("R10", 4, 4, 1);
    chk("R10 hdr unchanged", m_o[5], 0);
    chk("R10 ready", ready, 1);
  endtask

  task automatic t_returns;  // R7
    run_op(6, 0, 0, 0);
    chk("R7 free", d_free, 1); chk("R7 frame", d_ff, 1);
    chk_ptrs("R7", 1, 1, 4);
    chk("R7 rpc", ret_pc, 100); chk("R7 rdst", ret_dst, 5);
    run_op(6, 0, 0, 0);
    chk("R7 second frame", d_ff, 4);
    chk_ptrs("R7 second", 0, 0, 1);
    chk("R7 second rpc", ret_pc, 0);
  endtask

  initial begin
    for (int i = 0; i < FRAMES; i++) begin
      m_o[i] = '0; m_a[i] = '0; m_pc[i] = '0; m_dst[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_call();
    t_open();
    t_call();
    t_tail_open();
    t_cancel();
    t_nop_busy();
    t_tail_call();
    t_trap();
    t_returns();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule